// File: doc/BRIEF.md
# Hypercube Dimension-Order Packet Router

This block is the switching element that sits at one node of a binary hypercube of 2^DIM nodes. The node carries a DIM-bit address, given on `nodeId`. It has DIM network links and one local port. Link d joins this node to the neighbour whose address differs in bit d alone. Every packet carries its destination address next to its payload.

The router XORs the destination with `nodeId`. It sends the packet out on the link of the least significant bit that is set in that result, so each hop clears exactly one differing bit. A packet therefore arrives in at most DIM hops. When the XOR is zero, the packet leaves on the local port.

Every input and output uses a valid/ready handshake. Each output owns a single register, so a packet crosses the router with one cycle of latency. When several inputs contend for one output, a fixed priority picks the winner, and the others wait with ready low. For traffic injected at the local port there is a helper mode. In that mode the destination field is taken as a ring position and turned into a reflected Gray-code node address. Consecutive ring positions then land on cube neighbours.

Top module: `hcube_router`

## Requirements
- R1: Ports 0..DIM-1 are network links, and link d leads to the node whose address differs from `nodeId` only in bit d. A packet whose destination differs from `nodeId` leaves on the port numbered by the lowest set bit of (destination XOR `nodeId`). Its destination and data come out unchanged.
- R2: A packet whose destination equals `nodeId` leaves on port DIM, the local port.
- R3: A packet accepted at a rising edge (inValid and inReady both high) has its outValid high right after that same edge. Inputs that target different outputs are all accepted in the same cycle.
- R4: While an output has outValid high and outReady low, it keeps outValid high and holds its destination and data unchanged. No accepted packet is lost or duplicated.
- R5: When several valid inputs target one output, the lowest-numbered input is granted. The local port (number DIM) therefore has the lowest priority. Each input that is not granted sees inReady low and keeps its packet.
- R6: An input sees inReady high only when its target output register is empty, or is being emptied in that cycle (outReady high).
- R7: With `injRingMode` high, the destination on the local port is taken as a ring index i and replaced by i XOR (i>>1) before routing and forwarding. On link inputs the mode has no effect.
- R8: While reset is asserted, and right after it is released, every outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| nodeId | input | DIM | Address of this node; held stable in operation |
| inValid | input | DIM+1 | Per-input packet valid; bit DIM is the local port |
| inReady | output | DIM+1 | Per-input accept |
| inDest | input | (DIM+1)×DIM | Destination address per input |
| inData | input | (DIM+1)×DATA_W | Payload per input |
| injRingMode | input | 1 | Local input destination is a ring index (R7) |
| outValid | output | DIM+1 | Per-output packet valid |
| outReady | input | DIM+1 | Per-output accept by the neighbour or local sink |
| outDest | output | (DIM+1)×DIM | Destination address per output |
| outData | output | (DIM+1)×DATA_W | Payload per output |

## Verification
A wrong route decision shows up one cycle after acceptance: the packet appears on the wrong output, or its destination has changed. A bad grant shows up in the same cycle: the ready pattern across the inputs is wrong under contention. A corrupted output register shows up while the register is stalled, as a changed destination or payload, or as outValid dropping without a drain. A lost or doubled packet shows up one cycle after the stall is released.

// File: rtl/hcube_pkg.sv
package hcube_pkg;
  // Width of the source-select field; bounds the port count of one router.
  localparam int SRC_W = 4;
  localparam int MAX_PORTS = 1 << SRC_W;

  // Per-output strobe from control to datapath.
  typedef struct packed {
    logic             load;  // capture a packet into the output register
    logic [SRC_W-1:0] src;   // input port that feeds it
  } outStrobe_t;
endpackage

// File: rtl/hcube_ctrl.sv
module hcube_ctrl
  import hcube_pkg::*;
#(
  parameter  int DIM   = 3,
  localparam int NPORT = DIM + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DIM-1:0]               nodeId,
  input  logic [NPORT-1:0]             inValid,
  input  logic [NPORT-1:0][DIM-1:0]    effDest,
  input  logic [NPORT-1:0]             outValid,
  input  logic [NPORT-1:0]             outReady,
  output logic [NPORT-1:0]             inReady,
  output outStrobe_t [NPORT-1:0]       strobe
);

  logic [NPORT-1:0][DIM-1:0]   diffVec;
  logic [NPORT-1:0][SRC_W-1:0] targetPort;
  logic [NPORT-1:0][NPORT-1:0] want;   // want[o][p]
  logic [NPORT-1:0][NPORT-1:0] grant;  // grant[o][p]
  logic [NPORT-1:0]            outFree;

  // Route: lowest differing address bit picks the link, none picks local.
  for (genvar p = 0; p < NPORT; p++) begin : g_route
    assign diffVec[p] = effDest[p] ^ nodeId;
    always_comb begin
      targetPort[p] = SRC_W'(DIM);
      for (int d = DIM - 1; d >= 0; d--) begin
        if (diffVec[p][d]) targetPort[p] = SRC_W'(d);
      end
    end
  end

  // An output register can take a packet if empty or draining now.
  assign outFree = ~outValid | outReady;

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int p = 0; p < NPORT; p++) begin
        want[o][p] = inValid[p] && (targetPort[p] == SRC_W'(o));
      end
    end
  end

  // Fixed priority: lowest input index wins (local port is last).
  for (genvar o = 0; o < NPORT; o++) begin : g_arb
    assign grant[o] = want[o] & (~want[o] + NPORT'(1)) & {NPORT{outFree[o]}};
  end

  always_comb begin
    inReady = '0;
    for (int o = 0; o < NPORT; o++) begin
      inReady = inReady | grant[o];
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      strobe[o].load = |grant[o];
      strobe[o].src  = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (grant[o][p]) strobe[o].src = SRC_W'(p);
      end
    end
  end

  // ---------------- assertions ----------------
  logic [NPORT-1:0] skipped;   // accepted although a higher-priority peer waits
  logic [NPORT-1:0] overfill;  // accepted into a register that is stalled
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      skipped[p]  = 1'b0;
      overfill[p] = inValid[p] && inReady[p] && outValid[targetPort[p]]
                    && !outReady[targetPort[p]];
      for (int q = 0; q < p; q++) begin
        if (inValid[p] && inReady[p] && inValid[q] && !inReady[q]
            && targetPort[q] == targetPort[p]) skipped[p] = 1'b1;
      end
    end
  end

  assert_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    skipped == '0);

  assert_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    overfill == '0);

endmodule

// File: rtl/hcube_dp.sv
module hcube_dp
  import hcube_pkg::*;
#(
  parameter  int DIM    = 3,
  parameter  int DATA_W = 8,
  localparam int NPORT  = DIM + 1,
  localparam int PW     = $clog2(NPORT)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DIM-1:0]                nodeId,
  input  logic                          injRingMode,
  input  logic [NPORT-1:0][DIM-1:0]     inDest,
  input  logic [NPORT-1:0][DATA_W-1:0]  inData,
  input  outStrobe_t [NPORT-1:0]        strobe,
  input  logic [NPORT-1:0]              outReady,
  output logic [NPORT-1:0][DIM-1:0]     effDest,
  output logic [NPORT-1:0]              outValid,
  output logic [NPORT-1:0][DIM-1:0]     outDest,
  output logic [NPORT-1:0][DATA_W-1:0]  outData
);

  // Destination seen by routing; the local port may carry a ring index.
  for (genvar p = 0; p < NPORT; p++) begin : g_dest
    if (p == DIM) begin : g_local
      assign effDest[p] = injRingMode ? (inDest[p] ^ (inDest[p] >> 1)) : inDest[p];
    end else begin : g_link
      assign effDest[p] = inDest[p];
    end
  end

  // One output register per port.
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [PW-1:0]     srcIdx;
    logic              vReg;
    logic [DIM-1:0]    dReg;
    logic [DATA_W-1:0] pReg;

    assign srcIdx = strobe[o].src[PW-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               vReg <= 1'b0;
      else if (strobe[o].load) vReg <= 1'b1;
      else if (outReady[o])    vReg <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (strobe[o].load) begin
        dReg <= effDest[srcIdx];
        pReg <= inData[srcIdx];
      end
    end

    assign outValid[o] = vReg;
    assign outDest[o]  = dReg;
    assign outData[o]  = pReg;

    // ---------------- assertions ----------------
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobe[o].load |=> outValid[o]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[o] && !outReady[o]) |=>
        (outValid[o] && $stable(outDest[o]) && $stable(outData[o])));

    if (o < DIM) begin : g_linkchk
      assert_route_R1: assert property (@(posedge clk) disable iff (!rstN)
        outValid[o] |->
          (((outDest[o] ^ nodeId) & DIM'((1 << (o + 1)) - 1)) == DIM'(1 << o)));
    end else begin : g_localchk
      assert_eject_R2: assert property (@(posedge clk) disable iff (!rstN)
        outValid[o] |-> (outDest[o] == nodeId));
    end
  end

endmodule

// File: rtl/hcube_router.sv
module hcube_router
  import hcube_pkg::*;
#(
  parameter  int DIM    = 3,
  parameter  int DATA_W = 8,
  localparam int NPORT  = DIM + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DIM-1:0]                nodeId,
  input  logic [NPORT-1:0]              inValid,
  output logic [NPORT-1:0]              inReady,
  input  logic [NPORT-1:0][DIM-1:0]     inDest,
  input  logic [NPORT-1:0][DATA_W-1:0]  inData,
  input  logic                          injRingMode,
  output logic [NPORT-1:0]              outValid,
  input  logic [NPORT-1:0]              outReady,
  output logic [NPORT-1:0][DIM-1:0]     outDest,
  output logic [NPORT-1:0][DATA_W-1:0]  outData
);

  if (NPORT > MAX_PORTS) begin : g_sizeCheck
    $error("hcube_router: DIM too large for the source-select field");
  end

  outStrobe_t [NPORT-1:0]    strobe;
  logic [NPORT-1:0][DIM-1:0] effDest;

  hcube_ctrl #(.DIM(DIM)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .nodeId   (nodeId),
    .inValid  (inValid),
    .effDest  (effDest),
    .outValid (outValid),
    .outReady (outReady),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  hcube_dp #(.DIM(DIM), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .nodeId      (nodeId),
    .injRingMode (injRingMode),
    .inDest      (inDest),
    .inData      (inData),
    .strobe      (strobe),
    .outReady    (outReady),
    .effDest     (effDest),
    .outValid    (outValid),
    .outDest     (outDest),
    .outData     (outData)
  );

endmodule

// File: tb/hcube_router_tb_top.sv
`timescale 1ns/100ps
module hcube_router_tb_top;
  localparam int DIM = 3;
  localparam int DW  = 8;
  localparam int NP  = DIM + 1;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [DIM-1:0]          nodeId = 3'b101;
  logic [NP-1:0]           inValid = '0;
  logic [NP-1:0]           inReady;
  logic [NP-1:0][DIM-1:0]  inDest = '0;
  logic [NP-1:0][DW-1:0]   inData = '0;
  logic                    injRingMode = 1'b0;
  logic [NP-1:0]           outValid;
  logic [NP-1:0]           outReady = '1;
  logic [NP-1:0][DIM-1:0]  outDest;
  logic [NP-1:0][DW-1:0]   outData;

  hcube_router #(.DIM(DIM), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .nodeId(nodeId),
    .inValid(inValid), .inReady(inReady), .inDest(inDest), .inData(inData),
    .injRingMode(injRingMode),
    .outValid(outValid), .outReady(outReady), .outDest(outDest), .outData(outData)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // Fields: inPort[10:9] dest[8:6] ring[5] expPort[4:3] expDest[2:0]; node = 5.
  localparam logic [10:0] VECS [NVEC] = '{
    {2'd3, 3'd5, 1'b0, 2'd3, 3'd5},  // R2 eject
    {2'd3, 3'd4, 1'b0, 2'd0, 3'd4},  // R1 xor 001
    {2'd3, 3'd7, 1'b0, 2'd1, 3'd7},  // R1 xor 010
    {2'd3, 3'd1, 1'b0, 2'd2, 3'd1},  // R1 xor 100
    {2'd3, 3'd2, 1'b0, 2'd0, 3'd2},  // R1 xor 111 -> lowest
    {2'd0, 3'd6, 1'b0, 2'd0, 3'd6},  // R1 xor 011
    {2'd2, 3'd5, 1'b0, 2'd3, 3'd5},  // R2 from a link
    {2'd1, 3'd0, 1'b0, 2'd0, 3'd0},  // R1 xor 101
    {2'd3, 3'd3, 1'b1, 2'd0, 3'd2},  // R7 ring 3 -> 2
    {2'd3, 3'd6, 1'b1, 2'd3, 3'd5},  // R7 ring 6 -> 5
    {2'd3, 3'd7, 1'b1, 2'd0, 3'd4},  // R7 ring 7 -> 4
    {2'd3, 3'd5, 1'b1, 2'd1, 3'd7},  // R7 ring 5 -> 7
    {2'd3, 3'd2, 1'b1, 2'd1, 3'd3},  // R7 ring 2 -> 3
    {2'd0, 3'd3, 1'b1, 2'd1, 3'd3}   // R7 mode ignored on a link input
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearInputs();
    inValid = '0;
    injRingMode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 outValid in reset", 32'(outValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 outValid after reset", 32'(outValid), 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] ip, ep;
      logic [DIM-1:0] dst, ed;
      logic rm;
      string tag;
      ip = VECS[i][10:9]; dst = VECS[i][8:6]; rm = VECS[i][5];
      ep = VECS[i][4:3];  ed = VECS[i][2:0];
      tag = rm ? "R7" : ((ep == 2'd3) ? "R2" : "R1");
      @(negedge clk);
      clearInputs();
      inValid[ip] = 1'b1;
      inDest[ip]  = dst;
      inData[ip]  = 8'h40 + 8'(i);
      injRingMode = rm;
      #1;
      check("R3 ready on free output", 32'(inReady[ip]), 32'h1);
      @(negedge clk);
      check({tag, " port/dest/data"},
            {8'(outValid), 8'(outDest[ep]), 8'(outData[ep])},
            {8'(1 << ep), 8'(ed), 8'h40 + 8'(i)});
      clearInputs();
    end

    // R5: contention for output 0
    @(negedge clk);
    inValid[0] = 1'b1; inDest[0] = 3'd4; inData[0] = 8'hA0;
    inValid[1] = 1'b1; inDest[1] = 3'd6; inData[1] = 8'hA1;
    inValid[3] = 1'b1; inDest[3] = 3'd4; inData[3] = 8'hA3;
    #1 check("R5 grant input 0 first", 32'(inReady), 32'b0001);
    @(negedge clk);
    check("R5 first winner data", 32'(outData[0]), 32'hA0);
    inValid[0] = 1'b0;
    #1 check("R5 grant input 1 next", 32'(inReady), 32'b0010);
    @(negedge clk);
    check("R5 second winner data", 32'(outData[0]), 32'hA1);
    inValid[1] = 1'b0;
    #1 check("R5 local port last", 32'(inReady), 32'b1000);
    @(negedge clk);
    check("R5 local winner data", 32'(outData[0]), 32'hA3);
    clearInputs();

    // R3: parallel acceptance to distinct outputs
    @(negedge clk);
    inValid[0] = 1'b1; inDest[0] = 3'd4; inData[0] = 8'hC0;
    inValid[2] = 1'b1; inDest[2] = 3'd1; inData[2] = 8'hC2;
    #1 check("R3 both accepted", 32'(inReady), 32'b0101);
    @(negedge clk);
    check("R3 both outputs valid", 32'(outValid), 32'b0101);
    check("R3 both payloads", {outData[0], outData[2]}, {8'hC0, 8'hC2});
    clearInputs();

    // R4/R6: back-pressure on output 1
    @(negedge clk);
    outReady[1] = 1'b0;
    inValid[3] = 1'b1; inDest[3] = 3'd7; inData[3] = 8'hB0;
    @(negedge clk);
    inValid[3] = 1'b0;
    inValid[0] = 1'b1; inDest[0] = 3'd7; inData[0] = 8'hB1;
    #1 check("R6 blocked while output full", 32'(inReady[0]), 32'h0);
    @(negedge clk);
    check("R4 held packet", {31'(0), outValid[1]} << 8 | 32'(outData[1]), 32'h1B0);
    @(negedge clk);
    check("R4 still held", {outValid[1], outDest[1], outData[1]}, {1'b1, 3'd7, 8'hB0});
    outReady[1] = 1'b1;
    #1 check("R6 ready when draining", 32'(inReady[0]), 32'h1);
    @(negedge clk);
    check("R4 next packet follows", {outValid[1], outData[1]}, {1'b1, 8'hB1});
    clearInputs();
    @(negedge clk);
    check("R4 no duplicate after drain", 32'(outValid), 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule